// File: doc/BRIEF.md
# Dual-Pop Operand Stack

This block is the operand stack of a stack-oriented processor core. It holds up to sixteen 16-bit words in last-in, first-out order. The two most recent words are always visible on two output buses, so an arithmetic unit can read both operands of a binary operator without spending a cycle to fetch them.

Each cycle the block can discard zero, one or two words and can also accept one new word. When both happen in the same cycle, the discard is applied first and the new word lands on the shortened stack. As a result, "discard two, write one" replaces two operands with their result in a single clock.

The block counts its occupancy and raises empty and full flags. Any request it cannot honour leaves the contents untouched and sets a sticky error flag, which only reset clears. Requests it cannot honour are removing more words than are held, writing into a full stack, and the reserved discard code.

Top module: `dual_pop_stack`

## Requirements
- R1: While `rst_ni` is low and after it is released, depth is 0, `empty_o` is 1, `full_o` is 0, `err_o` is 0, both valid flags are 0 and both data outputs read 0.
- R2: A push (`push_i`=1, `pop_cnt_i`=0) on a non-full stack raises depth by one. On the next cycle `top_o` shows the pushed word and `second_o` shows the previous top.
- R3: `pop_cnt_i`=1 removes one word and `pop_cnt_i`=2 removes two, provided that many are held. The words underneath become the new top and second.
- R4: With a push and a nonzero pop count in the same cycle, the pop is applied first and the pushed word then becomes the top. Pop 2 plus push lowers depth by one. Pop 1 plus push keeps depth, and this is legal even when the stack is full.
- R5: A pop count larger than the current depth sets `err_o`. Contents and depth stay unchanged, and a push in the same cycle is dropped.
- R6: A push that would leave more than 16 entries after the pop is applied sets `err_o` and changes nothing.
- R7: `pop_cnt_i`=3 is reserved. It sets `err_o` and changes nothing, including any push in the same cycle.
- R8: Once set, `err_o` stays 1 until reset, whatever later commands do.
- R9: `top_valid_o` is 1 exactly when depth is at least 1, and `second_valid_o` exactly when depth is at least 2. A data output whose valid flag is 0 reads 0.
- R10: `depth_o` equals the number of held words (0 to 16). `empty_o` is 1 at depth 0 and `full_o` is 1 at depth 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write `push_data_i` on top this cycle |
| push_data_i | input | 16 | Word to push |
| pop_cnt_i | input | 2 | Number of words to discard: 0, 1, 2; 3 reserved |
| top_o | output | 16 | Most recent word |
| second_o | output | 16 | Word below the top |
| top_valid_o | output | 1 | Depth is at least 1 |
| second_valid_o | output | 1 | Depth is at least 2 |
| depth_o | output | 5 | Number of held words |
| empty_o | output | 1 | Depth is 0 |
| full_o | output | 1 | Depth is 16 |
| err_o | output | 1 | Sticky illegal-request flag |

## Verification
Discard and push can fall in the same cycle. The ordering rule decides whether such a cycle succeeds, overflows or underflows. The bench provokes the combination on purpose: pop 2 plus push on a deep stack, pop 1 plus push on a full stack, pop 2 plus push with one word held, and the reserved code together with a push. It also produces the combination in a long stretch of random commands. A behavioural queue model applies the pop before the push, and every output is compared with it after each clock. The top word, the second word, the depth and the error flag therefore show any misordering on the next cycle.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    POP_NONE = 2'd0,
    POP_ONE  = 2'd1,
    POP_TWO  = 2'd2,
    POP_BAD  = 2'd3
  } pop_e;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [CNT_W-1:0] depth_i,
  input  logic             push_i,
  input  pop_e             pop_i,
  output logic             fault_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] depth_nxt_o
);
  logic [CNT_W-1:0] pop_amt;
  logic [CNT_W-1:0] base;
  logic             under;
  logic             over;

  // pop is applied before push
  always_comb begin
    pop_amt     = CNT_W'(pop_i);
    under       = (pop_i == POP_BAD) || (pop_amt > depth_i);
    base        = depth_i - pop_amt;
    over        = !under && push_i && (base == CNT_W'(DEPTH));
    fault_o     = under || over;
    wr_en_o     = !fault_o && push_i;
    wr_idx_o    = IDX_W'(base);
    depth_nxt_o = fault_o ? depth_i : base + CNT_W'(push_i);
  end
endmodule

// File: rtl/stack_store.sv
module stack_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] slots_o [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slots_o[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        slots_o[g] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/stack_peek.sv
module stack_peek #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [DATA_W-1:0] slots_i [DEPTH],
  input  logic [CNT_W-1:0]  depth_i,
  output logic [DATA_W-1:0] top_o,
  output logic [DATA_W-1:0] second_o,
  output logic              top_valid_o,
  output logic              second_valid_o
);
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] sec_idx;

  always_comb begin
    top_idx        = IDX_W'(depth_i - CNT_W'(1));
    sec_idx        = IDX_W'(depth_i - CNT_W'(2));
    top_valid_o    = depth_i != '0;
    second_valid_o = depth_i > CNT_W'(1);
    top_o          = top_valid_o    ? slots_i[top_idx] : '0;
    second_o       = second_valid_o ? slots_i[sec_idx] : '0;
  end
endmodule

// File: rtl/dual_pop_stack.sv
module dual_pop_stack
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DATA_W-1:0]            push_data_i,
  input  logic [1:0]                   pop_cnt_i,
  output logic [DATA_W-1:0]            top_o,
  output logic [DATA_W-1:0]            second_o,
  output logic                         top_valid_o,
  output logic                         second_valid_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic                         err_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [CNT_W-1:0]  depth_q;
  logic [CNT_W-1:0]  depth_nxt;
  logic              err_q;
  logic              fault;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] slots [DEPTH];

  stack_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_ctrl (
    .depth_i     (depth_q),
    .push_i      (push_i),
    .pop_i       (pop_e'(pop_cnt_i)),
    .fault_o     (fault),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .depth_nxt_o (depth_nxt)
  );

  stack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_data_i),
    .slots_o   (slots)
  );

  stack_peek #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_peek (
    .slots_i        (slots),
    .depth_i        (depth_q),
    .top_o          (top_o),
    .second_o       (second_o),
    .top_valid_o    (top_valid_o),
    .second_valid_o (second_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      depth_q <= depth_nxt;
      err_q   <= err_q | fault;
    end
  end

  assign depth_o = depth_q;
  assign empty_o = depth_q == '0;
  assign full_o  = depth_q == CNT_W'(DEPTH);
  assign err_o   = err_q;
endmodule

// File: rtl/stack_chk.sv
module stack_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic [1:0]        pop_cnt_i,
  input logic [DATA_W-1:0] top_o,
  input logic [DATA_W-1:0] second_o,
  input logic              top_valid_o,
  input logic              second_valid_o,
  input logic [CNT_W-1:0]  depth_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              err_o
);
  // R10
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= CNT_W'(DEPTH));

  // R9
  valid_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_valid_o |-> top_valid_o && !empty_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R7
  bad_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_cnt_i == 2'd3 |=> err_o && depth_o == $past(depth_o));

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_cnt_i != 2'd3 && CNT_W'(pop_cnt_i) > depth_o) |=> err_o && $stable(depth_o) && $stable(top_o));

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_cnt_i == 2'd0 && full_o) |=> err_o && full_o && $stable(top_o));

  // R2
  push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_cnt_i == 2'd0 && !full_o) |=>
      top_o == $past(push_data_i) && second_o == $past(top_o) && depth_o == $past(depth_o) + CNT_W'(1));

  // R4
  replace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_cnt_i == 2'd2 && depth_o >= CNT_W'(2)) |=>
      top_o == $past(push_data_i) && depth_o == $past(depth_o) - CNT_W'(1));
endmodule

bind dual_pop_stack stack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_dual_pop_stack.sv
`timescale 1ns/1ps
module test_dual_pop_stack;
  localparam int DW = 16;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push = 1'b0;
  logic [DW-1:0] pdata = '0;
  logic [1:0]    pcnt = 2'd0;
  logic [DW-1:0] top, second;
  logic          top_v, sec_v, empty, full, err;
  logic [4:0]    depth;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  bit m_err = 0;

  always #2.5 clk = ~clk;

  dual_pop_stack i_dual_pop_stack (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push), .push_data_i(pdata),
    .pop_cnt_i(pcnt), .top_o(top), .second_o(second), .top_valid_o(top_v),
    .second_valid_o(sec_v), .depth_o(depth), .empty_o(empty), .full_o(full),
    .err_o(err)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int n = q.size();
    cmp(tag, "top", 32'(top), n >= 1 ? 32'(q[n-1]) : 32'd0);
    cmp(tag, "second", 32'(second), n >= 2 ? 32'(q[n-2]) : 32'd0);
    cmp(tag, "err", 32'(err), 32'(m_err));
    cmp("R9", "top_valid", 32'(top_v), 32'(n >= 1));
    cmp("R9", "second_valid", 32'(sec_v), 32'(n >= 2));
    cmp("R10", "depth", 32'(depth), 32'(n));
    cmp("R10", "empty", 32'(empty), 32'(n == 0));
    cmp("R10", "full", 32'(full), 32'(n == DEPTH));
  endtask

  // reference: pop first, then push; any illegal request changes nothing
  task automatic model(bit p, logic [DW-1:0] d, int pc);
    if (pc == 3 || pc > q.size()) m_err = 1;
    else if (p && (q.size() - pc) == DEPTH) m_err = 1;
    else begin
      repeat (pc) void'(q.pop_back());
      if (p) q.push_back(d);
    end
  endtask

  task automatic step(string tag, bit p, logic [DW-1:0] d, int pc);
    @(negedge clk);
    push = p; pdata = d; pcnt = 2'(pc);
    @(posedge clk);
    model(p, d, pc);
    @(negedge clk);
    push = 0; pcnt = 0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    q.delete(); m_err = 0;
    #1 check_all("R1");
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 pushes
    for (int i = 0; i < 5; i++) step("R2", 1, 16'hA000 + 16'(i), 0);
    // R3 pops
    step("R3", 0, 0, 1);
    step("R3", 0, 0, 2);
    // R4 combined
    step("R2", 1, 16'h1111, 0);
    step("R4", 1, 16'hBEEF, 2);
    step("R4", 1, 16'hCAFE, 1);
    // fill to full
    while (q.size() < DEPTH) step("R2", 1, 16'(q.size() * 7 + 3), 0);
    step("R4", 1, 16'h7777, 1);
    step("R6", 1, 16'hDEAD, 0);
    step("R8", 0, 0, 1);
    step("R8", 1, 16'h4242, 2);
    do_reset();
    // R5 underflow, with push dropped
    step("R2", 1, 16'h0042, 0);
    step("R5", 1, 16'h5555, 2);
    step("R8", 1, 16'h6666, 0);
    do_reset();
    step("R5", 0, 0, 1);
    do_reset();
    // R7 reserved code
    step("R2", 1, 16'h0101, 0);
    step("R2", 1, 16'h0202, 0);
    step("R7", 1, 16'h0303, 3);
    step("R8", 0, 0, 0);
    do_reset();
    // mixed random traffic, periodic reset to clear error
    for (int k = 0; k < 600; k++) begin
      int pc;
      bit p;
      if (k % 60 == 59) do_reset();
      p = ($urandom % 100) < 55;
      pc = $urandom % 4;
      if (pc == 3 && ($urandom % 8) != 0) pc = 1;
      step("R4", p, 16'($urandom), pc);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule